// File: doc/BRIEF.md
# Share-Weighted Two-Master Memory Arbiter

The block sits in front of one shared memory port that two bus masters both want. Each master presents a request together with a write flag, a word address and write data. In every cycle the arbiter grants at most one master, steers that master's access onto the memory, and answers with a same-cycle grant. A read also returns its data one cycle later, flagged by a valid pulse that goes only to the master that issued it. A small registered memory model is built into the datapath and stands in for the real slave.

Arbitration follows a round-robin order in which each master owns priority for a programmable number of contended cycles, its share. A master that is alone on the port is granted at once and spends no share. A master that loses keeps its request up and competes again in the next cycle. The memory side can take a write only every second cycle. A write that arrives in the recovery cycle after a write is held back: it is not granted and it does not count as contention, so a read from the other master can use that cycle.

Top module: `shmem_share_arb`

## Requirements
- R1: After reset no grant and no read-valid is asserted, master 0 owns priority and its count of contended wins is zero.
- R2: At most one of gnt0/gnt1 is high in any cycle, and a grant is only given to a master whose request is high.
- R3: A master that is eligible while the other master is not eligible is granted in that same cycle. A master is eligible when its request is high and it is not a write stalled by R7.
- R4: When both masters are eligible, the current priority owner is granted. The owner keeps priority for cfgShare of its contended wins, so it wins cfgShare consecutive contended cycles. After the last of these wins, priority passes to the other master and the win count restarts at zero. Over long contention, master 0 wins cfgShare0/(cfgShare0+cfgShare1) of contended cycles.
- R5: A share value of 0 behaves exactly like a share of 1.
- R6: A master that is denied and keeps its request asserted with the same access is granted in a later cycle, without being dropped.
- R7: No write is granted in the cycle directly after a write grant. A write request in that cycle is stalled and counts neither as contention nor as a use of share. Reads may be granted on consecutive cycles and directly after a write.
- R8: When the priority owner's request is low while the other master requests, priority passes to the other master at that clock edge and the win count restarts at zero.
- R9: A granted read to address A raises rvalid of that master only, exactly one cycle after the grant. rdata then holds the word last written to A. A granted write stores wdata at its address at the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgShare0 | input | SHARE_W | Contended-cycle share of master 0 (0 acts as 1) |
| cfgShare1 | input | SHARE_W | Contended-cycle share of master 1 (0 acts as 1) |
| req0 | input | 1 | Master 0 access request, held until granted |
| wr0 | input | 1 | Master 0 access is a write when 1, a read when 0 |
| addr0 | input | ADDR_W | Master 0 word address |
| wdata0 | input | DATA_W | Master 0 write data |
| gnt0 | output | 1 | Master 0 granted this cycle |
| rvalid0 | output | 1 | Read data for master 0 valid this cycle |
| rdata0 | output | DATA_W | Read data to master 0 |
| req1 | input | 1 | Master 1 access request, held until granted |
| wr1 | input | 1 | Master 1 access is a write when 1, a read when 0 |
| addr1 | input | ADDR_W | Master 1 word address |
| wdata1 | input | DATA_W | Master 1 write data |
| gnt1 | output | 1 | Master 1 granted this cycle |
| rvalid1 | output | 1 | Read data for master 1 valid this cycle |
| rdata1 | output | DATA_W | Read data to master 1 |

## Verification
The arbiter is first driven with two masters issuing nonstop reads under unequal shares and then under zero shares. These runs separate a correct share count from an off-by-one count or a plain alternating scheme. Nonstop writes from both sides expose any break in write spacing. A short directed sequence in which a write lands in the recovery cycle next to a read shows that a stalled write neither blocks the read nor takes the contended slot. A second short sequence, in which the owner drops its request, shows the hand-over of priority. Long random traffic with mixed load, write ratio and share pairs is then compared cycle by cycle against a behavioural model of grants, read data and memory contents.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
  // Strobes from arbitration control to the memory datapath
  typedef struct packed {
    logic [1:0] gnt;    // one-hot grant, bit i for master i
    logic       sel;    // selected master index
    logic       memWr;  // write the selected access this cycle
    logic       memRd;  // read the selected access this cycle
  } arbStrobe_t;
endpackage

// File: rtl/shmem_arb_ctrl.sv
module shmem_arb_ctrl
  import shmem_arb_pkg::*;
#(
  parameter int SHARE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         req,
  input  logic [1:0]         wr,
  input  logic [SHARE_W-1:0] share0,
  input  logic [SHARE_W-1:0] share1,
  output arbStrobe_t         strobe
);
  logic               ownerQ;    // master holding round-robin priority
  logic [SHARE_W-1:0] usedQ;     // contended wins taken by owner
  logic               recovQ;    // memory in write recovery cycle
  logic [1:0]         elig;
  logic               contend;
  logic               anyGnt;
  logic               win;
  logic [SHARE_W-1:0] shareOwn;
  logic [SHARE_W:0]   limit;
  logic [SHARE_W:0]   usedNext;

  // A write that meets the recovery cycle is held, not counted as a contender
  assign elig    = req & ~(wr & {2{recovQ}});
  assign contend = &elig;
  assign anyGnt  = |elig;
  assign win     = contend ? ownerQ : elig[1];

  assign shareOwn = ownerQ ? share1 : share0;
  assign limit    = (shareOwn == '0) ? {{SHARE_W{1'b0}}, 1'b1} : {1'b0, shareOwn};
  assign usedNext = {1'b0, usedQ} + {{SHARE_W{1'b0}}, 1'b1};

  always_comb begin
    strobe.gnt   = 2'b00;
    strobe.sel   = win;
    strobe.memWr = 1'b0;
    strobe.memRd = 1'b0;
    if (anyGnt) begin
      strobe.gnt[win] = 1'b1;
      strobe.memWr    = wr[win];
      strobe.memRd    = ~wr[win];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= 1'b0;
      usedQ  <= '0;
      recovQ <= 1'b0;
    end else begin
      recovQ <= anyGnt & wr[win];
      if (contend) begin
        if (usedNext >= limit) begin
          ownerQ <= ~ownerQ;
          usedQ  <= '0;
        end else begin
          usedQ <= usedNext[SHARE_W-1:0];
        end
      end else if (!req[ownerQ] && req[~ownerQ]) begin
        ownerQ <= ~ownerQ;
        usedQ  <= '0;
      end
    end
  end
endmodule

// File: rtl/shmem_arb_dpath.sv
module shmem_arb_dpath
  import shmem_arb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [ADDR_W-1:0] addr1,
  input  logic [DATA_W-1:0] wdata0,
  input  logic [DATA_W-1:0] wdata1,
  output logic [1:0]        rvalid,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] rdataQ;
  logic [1:0]        rvalidQ;

  assign selAddr = strobe.sel ? addr1 : addr0;
  assign selData = strobe.sel ? wdata1 : wdata0;

  always_ff @(posedge clk) begin
    if (strobe.memWr) memArr[selAddr] <= selData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ  <= '0;
      rvalidQ <= 2'b00;
    end else begin
      rvalidQ <= strobe.memRd ? strobe.gnt : 2'b00;
      if (strobe.memRd) rdataQ <= memArr[selAddr];
    end
  end

  assign rvalid = rvalidQ;
  assign rdata  = rdataQ;
endmodule

// File: rtl/shmem_share_arb.sv
module shmem_share_arb
  import shmem_arb_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int SHARE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SHARE_W-1:0] cfgShare0,
  input  logic [SHARE_W-1:0] cfgShare1,
  input  logic               req0,
  input  logic               wr0,
  input  logic [ADDR_W-1:0]  addr0,
  input  logic [DATA_W-1:0]  wdata0,
  output logic               gnt0,
  output logic               rvalid0,
  output logic [DATA_W-1:0]  rdata0,
  input  logic               req1,
  input  logic               wr1,
  input  logic [ADDR_W-1:0]  addr1,
  input  logic [DATA_W-1:0]  wdata1,
  output logic               gnt1,
  output logic               rvalid1,
  output logic [DATA_W-1:0]  rdata1
);
  arbStrobe_t        strobe;
  logic [1:0]        rvalid;
  logic [DATA_W-1:0] rdata;

  shmem_arb_ctrl #(.SHARE_W(SHARE_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .req({req1, req0}), .wr({wr1, wr0}),
    .share0(cfgShare0), .share1(cfgShare1),
    .strobe(strobe)
  );

  shmem_arb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .addr0(addr0), .addr1(addr1), .wdata0(wdata0), .wdata1(wdata1),
    .rvalid(rvalid), .rdata(rdata)
  );

  assign gnt0    = strobe.gnt[0];
  assign gnt1    = strobe.gnt[1];
  assign rvalid0 = rvalid[0];
  assign rvalid1 = rvalid[1];
  assign rdata0  = rdata;
  assign rdata1  = rdata;
endmodule

// File: rtl/shmem_share_arb_chk.sv
module shmem_share_arb_chk (
  input logic clk,
  input logic rstN,
  input logic req0,
  input logic req1,
  input logic wr0,
  input logic wr1,
  input logic gnt0,
  input logic gnt1,
  input logic rvalid0,
  input logic rvalid1
);
  logic wrGnt;
  assign wrGnt = (gnt0 && wr0) || (gnt1 && wr1);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gnt1, gnt0}));

  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gnt0 |-> req0) and (gnt1 |-> req1));

  p_lone_read_granted_r3: assert property (@(posedge clk) disable iff (!rstN)
    (req0 && !wr0 && !req1) |-> gnt0);

  p_lone_read_granted1_r3: assert property (@(posedge clk) disable iff (!rstN)
    (req1 && !wr1 && !req0) |-> gnt1);

  p_write_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrGnt |=> !wrGnt);

  p_rvalid_after_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gnt0 && !wr0) |=> (rvalid0 && !rvalid1));

  p_rvalid_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rvalid1, rvalid0}));
endmodule

bind shmem_share_arb shmem_share_arb_chk chk_i (
  .clk(clk), .rstN(rstN), .req0(req0), .req1(req1), .wr0(wr0), .wr1(wr1),
  .gnt0(gnt0), .gnt1(gnt1), .rvalid0(rvalid0), .rvalid1(rvalid1)
);

// File: tb/shmem_share_arb_tb.sv
`timescale 1ns/1ps
module shmem_share_arb_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [SW-1:0] cfgShare0 = '0, cfgShare1 = '0;
  logic          req0 = 0, wr0 = 0, req1 = 0, wr1 = 0;
  logic [AW-1:0] addr0 = '0, addr1 = '0;
  logic [DW-1:0] wdata0 = '0, wdata1 = '0;
  logic          gnt0, gnt1, rvalid0, rvalid1;
  logic [DW-1:0] rdata0, rdata1;

  always #2 clk = ~clk;

  shmem_share_arb #(.ADDR_W(AW), .DATA_W(DW), .SHARE_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgShare0(cfgShare0), .cfgShare1(cfgShare1),
    .req0(req0), .wr0(wr0), .addr0(addr0), .wdata0(wdata0),
    .gnt0(gnt0), .rvalid0(rvalid0), .rdata0(rdata0),
    .req1(req1), .wr1(wr1), .addr1(addr1), .wdata1(wdata1),
    .gnt1(gnt1), .rvalid1(rvalid1), .rdata1(rdata1)
  );

  int tests = 0, fails = 0;

  // Master-side stimulus state
  bit          pend[2];
  bit          pwr[2];
  int          paddr[2];
  int          pdat[2];

  // Behavioural reference state
  int          mOwner, mUsed;
  bit          mRecov, mRv0, mRv1;
  int          mRd;
  int          memM[16];
  int          gCnt[2], wrGCnt, lastG0, lastG1;

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic doReset();
    pend[0] = 0; pend[1] = 0;
    @(negedge clk);
    req0 = 0; req1 = 0; rstN = 0;
    repeat (3) @(posedge clk);
    mOwner = 0; mUsed = 0; mRecov = 0; mRv0 = 0; mRv1 = 0;
    @(negedge clk);
    rstN = 1;
    #1;
    check(gnt0 === 1'b0 && gnt1 === 1'b0, "R1 grant after reset", {gnt1, gnt0}, 0);
    check(rvalid0 === 1'b0 && rvalid1 === 1'b0, "R1 rvalid after reset", {rvalid1, rvalid0}, 0);
  endtask

  task automatic clrCounts();
    gCnt[0] = 0; gCnt[1] = 0; wrGCnt = 0;
  endtask

  task automatic runCycle();
    bit e0, e1, con, any, xg0, xg1;
    int w;
    string tag;
    @(negedge clk);
    req0 = pend[0]; wr0 = pwr[0]; addr0 = AW'(paddr[0]); wdata0 = DW'(pdat[0]);
    req1 = pend[1]; wr1 = pwr[1]; addr1 = AW'(paddr[1]); wdata1 = DW'(pdat[1]);
    #1;
    e0  = pend[0] && !(pwr[0] && mRecov);
    e1  = pend[1] && !(pwr[1] && mRecov);
    con = e0 && e1;
    any = e0 || e1;
    w   = con ? mOwner : (e1 ? 1 : 0);
    xg0 = any && (w == 0);
    xg1 = any && (w == 1);
    if (con) tag = "R4 contended grant";
    else if ((pend[0] && !e0) || (pend[1] && !e1)) tag = "R7 stalled write grant";
    else tag = "R3 uncontested grant";
    check(gnt0 === xg0 && gnt1 === xg1, tag, {gnt1, gnt0}, {xg1, xg0});
    check(rvalid0 === mRv0 && rvalid1 === mRv1, "R9 rvalid", {rvalid1, rvalid0}, {mRv1, mRv0});
    if (mRv0) check(rdata0 === DW'(mRd), "R9 rdata0", rdata0, mRd);
    if (mRv1) check(rdata1 === DW'(mRd), "R9 rdata1", rdata1, mRd);
    lastG0 = gnt0; lastG1 = gnt1;
    // advance the reference to the coming edge
    mRv0 = xg0 && !pwr[0];
    mRv1 = xg1 && !pwr[1];
    if (any) begin
      if (pwr[w]) begin
        memM[paddr[w]] = pdat[w] & 16'hFFFF;
        wrGCnt++;
      end else mRd = memM[paddr[w]];
      gCnt[w]++;
      pend[w] = 0;
    end
    mRecov = any && pwr[w];
    if (con) begin
      if (mUsed + 1 >= eff(mOwner ? int'(cfgShare1) : int'(cfgShare0))) begin
        mOwner = 1 - mOwner; mUsed = 0;
      end else mUsed++;
    end else if (!pend_req(mOwner) && pend_req(1 - mOwner)) begin
      mOwner = 1 - mOwner; mUsed = 0;
    end
  endtask

  // request levels as driven this cycle (pend may already be cleared by grant)
  function automatic bit pend_req(int m);
    return (m == 0) ? req0 : req1;
  endfunction

  task automatic setReq(int m, bit w, int a, int d);
    pend[m] = 1; pwr[m] = w; paddr[m] = a; pdat[m] = d & 16'hFFFF;
  endtask

  task automatic randomPhase(int s0, int s1, int load, int wpct, int n);
    cfgShare0 = SW'(s0); cfgShare1 = SW'(s1);
    doReset();
    for (int c = 0; c < n; c++) begin
      for (int m = 0; m < 2; m++)
        if (!pend[m] && $urandom_range(99) < load)
          setReq(m, $urandom_range(99) < wpct, $urandom_range(15), $urandom);
      runCycle();
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clrCounts();
    cfgShare0 = 4'd1; cfgShare1 = 4'd1;
    doReset();
    // Fill memory from master 0 alone (R9 write path, R3 lone grant)
    for (int k = 0; k < 16; k++) begin
      setReq(0, 1, k, $urandom);
      while (pend[0]) runCycle();
    end
    for (int k = 0; k < 16; k++) begin
      setReq(1, 0, k, 0);
      while (pend[1]) runCycle();
    end

    // R4/R6: shares 3:1, both reading nonstop for 40 contended cycles
    cfgShare0 = 4'd3; cfgShare1 = 4'd1;
    doReset(); clrCounts();
    for (int c = 0; c < 40; c++) begin
      for (int m = 0; m < 2; m++) if (!pend[m]) setReq(m, 0, (c + m) % 16, 0);
      runCycle();
    end
    check(gCnt[0] == 30, "R4 share 3:1 wins of master0", gCnt[0], 30);
    check(gCnt[1] == 10, "R6 denied master1 still served", gCnt[1], 10);

    // R5: both shares zero alternate
    cfgShare0 = 4'd0; cfgShare1 = 4'd0;
    doReset(); clrCounts();
    for (int c = 0; c < 20; c++) begin
      for (int m = 0; m < 2; m++) if (!pend[m]) setReq(m, 0, c % 16, 0);
      runCycle();
      check(lastG0 == ((c % 2) == 0), "R5 zero share alternation", lastG0, (c % 2) == 0);
    end

    // R7: both writing nonstop, writes at most every second cycle
    cfgShare0 = 4'd2; cfgShare1 = 4'd2;
    doReset(); clrCounts();
    for (int c = 0; c < 20; c++) begin
      for (int m = 0; m < 2; m++) if (!pend[m]) setReq(m, 1, c % 16, $urandom);
      runCycle();
    end
    check(wrGCnt == 10, "R7 write grants in 20 cycles", wrGCnt, 10);

    // R7: stalled write lets the other master's read through
    doReset();
    setReq(0, 1, 3, 16'hBEEF); setReq(1, 0, 5, 0);
    runCycle();
    check(lastG0 == 1, "R7 first write granted to owner", lastG0, 1);
    setReq(0, 1, 4, 16'h1234);
    runCycle();
    check(lastG1 == 1 && lastG0 == 0, "R7 read passes stalled write", {lastG1, lastG0}, 2);
    runCycle();
    check(lastG0 == 1, "R7 held write granted after recovery", lastG0, 1);
    setReq(1, 0, 3, 0);
    runCycle();
    runCycle();
    check(rvalid1 === 1'b1 && rdata1 === 16'hBEEF, "R9 read returns written word", rdata1, 16'hBEEF);

    // R8: owner drops its request, priority passes
    cfgShare0 = 4'd4; cfgShare1 = 4'd4;
    doReset();
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 2; m++) if (!pend[m]) setReq(m, 0, 1, 0);
      runCycle();
    end
    runCycle();
    check(lastG1 == 1, "R8 lone master1 granted", lastG1, 1);
    setReq(0, 0, 2, 0); setReq(1, 0, 6, 0);
    runCycle();
    check(lastG1 == 1 && lastG0 == 0, "R8 priority moved to master1", {lastG1, lastG0}, 2);

    // Random traffic against the reference model (R2..R9)
    randomPhase(3, 1, 70, 30, 800);
    randomPhase(0, 5, 90, 50, 800);
    randomPhase(2, 2, 50, 60, 800);
    randomPhase(7, 0, 100, 20, 800);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule